// File: doc/BRIEF.md
# Breakpoint and Watchpoint Match Unit

This block watches the processor's instruction fetches and data accesses and compares them with a small set of address triggers. Each trigger has a control word and an address. The control word enables instruction-address matching, load matching or store matching. It also selects the privilege levels at which the trigger may fire and the size of a byte window around the trigger address for data accesses. When a fetch or an access matches an enabled trigger at the current privilege level, the block raises a breakpoint-exception request. The request carries the index of the trigger that fired.

The core uses the request to take a breakpoint exception before the matching instruction retires or before the memory access changes any state. Requests are registered. They appear exactly one clock after the cycle in which the fetch or access strobe was presented, and they last one cycle for each matching strobe cycle. When several triggers match, a fixed priority picks one. An instruction match ranks above a data match, and within each kind the lowest trigger index wins.

Top module: `dbg_match_unit`

## Requirements
- R1: An instruction match happens when `fetch_valid` is high, control bit 2 (execute) of a trigger is set, and `fetch_pc` equals that trigger's address exactly.
- R2: A data match happens when `data_load` is high and control bit 0 (load) is set, or when `data_store` is high and control bit 1 (store) is set, and the access overlaps the trigger's watch window.
- R3: A match counts only if control bit (3 + `priv_lvl`) is set. Bit 3 permits user (level 0), bit 4 permits supervisor (level 1) and bit 6 permits machine (level 3).
- R4: A trigger with none of control bits 3, 4 and 6 set, or with none of control bits 0, 1 and 2 set, never fires.
- R5: Control bits 17:16 select the watch window starting at the trigger address. Code 1 gives 1 byte, code 2 gives 2 bytes, code 3 gives 4 bytes and code 0 gives 8 bytes.
- R6: A data access covers 2^`data_lsize` bytes starting at `data_addr`. It matches when any of its bytes falls inside the window. Addresses do not wrap.
- R7: When more than one trigger matches with the same kind of match, `brk_idx` reports the lowest index.
- R8: An instruction match and a data match in the same cycle produce a single request. The index reported is the one from the instruction match.
- R9: `brk_req` is high in the cycle after each cycle that had a match, and low after any cycle without one. `brk_idx` is 0 whenever `brk_req` is low.
- R10: A synchronous active-high `rst` clears `brk_req` and `brk_idx` at the next edge, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_lvl | input | 2 | Current privilege level |
| trig_ctrl | input | NUM_TRIG*XLEN | Control words; trigger i in bits [i*XLEN +: XLEN] |
| trig_addr | input | NUM_TRIG*XLEN | Trigger addresses; trigger i in bits [i*XLEN +: XLEN] |
| fetch_valid | input | 1 | Instruction fetch strobe |
| fetch_pc | input | XLEN | Fetch address |
| data_load | input | 1 | Load access strobe |
| data_store | input | 1 | Store access strobe |
| data_addr | input | XLEN | Data access start address |
| data_lsize | input | 2 | log2 of the access size in bytes |
| brk_req | output | 1 | Breakpoint-exception request (registered) |
| brk_idx | output | IDX_W | Index of the trigger that fired |

## Verification
Most internal faults in this block show up at the ports exactly one clock after the faulty cycle, because the output register holds the only state. A bad window boundary or overlap compare shows as a missing or extra request when a data access lands on the first or last byte of a window. A wrong privilege bit select fires or suppresses a request only at one privilege level. A wrong priority order shows only when two triggers, or an instruction match and a data match, land in the same cycle. The bench therefore steers addresses onto window edges and shared addresses, and compares the outputs with its model on every clock.

// File: rtl/dbg_match_pkg.sv
package dbg_match_pkg;

  // Control word field positions
  localparam int CB_LOAD   = 0;
  localparam int CB_STORE  = 1;
  localparam int CB_EXEC   = 2;
  localparam int CB_PRIV0  = 3;   // privilege filter base: bit (3 + level)
  localparam int CB_USER   = 3;
  localparam int CB_SUPER  = 4;
  localparam int CB_MACH   = 6;
  localparam int CB_SIZE   = 16;  // two-bit window code at [17:16]
  localparam int CB_MSB    = 17;  // highest control bit the unit reads

  localparam int WIN_W     = 4;   // width of a window byte count (max 8)

  // Window length in bytes for a size code
  function automatic logic [WIN_W-1:0] win_bytes(input logic [1:0] code);
    case (code)
      2'd1:    win_bytes = 4'd1;
      2'd2:    win_bytes = 4'd2;
      2'd3:    win_bytes = 4'd4;
      default: win_bytes = 4'd8;
    endcase
  endfunction

  // Byte count of a data access from its log2 size
  function automatic logic [WIN_W-1:0] acc_bytes(input logic [1:0] lsize);
    acc_bytes = 4'd1 << lsize;
  endfunction

  typedef struct packed {
    logic exec_hit;
    logic data_hit;
  } slot_hit_t;

endpackage

// File: rtl/watch_window.sv
module watch_window
  import dbg_match_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] base,
  input  logic [1:0]      size_code,
  input  logic [XLEN-1:0] acc_addr,
  input  logic [1:0]      acc_lsize,
  output logic            overlap
);

  localparam int EXT_W = XLEN + 1;
  localparam int PAD_W = EXT_W - WIN_W;

  logic [EXT_W-1:0] win_lo, win_hi, acc_lo, acc_hi;

  // One extra bit keeps the end addresses from wrapping
  always_comb begin
    win_lo  = {1'b0, base};
    acc_lo  = {1'b0, acc_addr};
    win_hi  = win_lo + {{PAD_W{1'b0}}, win_bytes(size_code)};
    acc_hi  = acc_lo + {{PAD_W{1'b0}}, acc_bytes(acc_lsize)};
    overlap = (acc_lo < win_hi) && (win_lo < acc_hi);
  end

endmodule

// File: rtl/trig_slot.sv
module trig_slot
  import dbg_match_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] ctrl,
  input  logic [XLEN-1:0] taddr,
  input  logic [1:0]      priv,
  input  logic            fetch_valid,
  input  logic [XLEN-1:0] fetch_pc,
  input  logic            data_load,
  input  logic            data_store,
  input  logic [XLEN-1:0] data_addr,
  input  logic [1:0]      data_lsize,
  output slot_hit_t       hit
);

  logic [3:0] priv_bits;
  logic       armed;
  logic       priv_ok;
  logic       kind_ok;
  logic       in_window;

  watch_window #(.XLEN(XLEN)) u_win (
    .base      (taddr),
    .size_code (ctrl[CB_SIZE +: 2]),
    .acc_addr  (data_addr),
    .acc_lsize (data_lsize),
    .overlap   (in_window)
  );

  always_comb begin
    priv_bits = ctrl[CB_PRIV0 +: 4];
    armed     = (ctrl[CB_USER] | ctrl[CB_SUPER] | ctrl[CB_MACH]) &&
                (ctrl[CB_LOAD] | ctrl[CB_STORE] | ctrl[CB_EXEC]);
    priv_ok   = priv_bits[priv];
    kind_ok   = (data_load && ctrl[CB_LOAD]) || (data_store && ctrl[CB_STORE]);
    hit.exec_hit = armed && priv_ok && ctrl[CB_EXEC] && fetch_valid &&
                   (fetch_pc == taddr);
    hit.data_hit = armed && priv_ok && kind_ok && in_window;
  end

endmodule

// File: rtl/first_hit_pick.sv
module first_hit_pick #(
  parameter int N     = 2,
  parameter int IDX_W = 1
) (
  input  logic [N-1:0]     hits,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  // Scan from the top so the lowest set index is the last written
  always_comb begin
    any = |hits;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
  import dbg_match_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NUM_TRIG = 2,
  localparam int IDX_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0]               priv_lvl,
  input  logic [NUM_TRIG*XLEN-1:0] trig_ctrl,
  input  logic [NUM_TRIG*XLEN-1:0] trig_addr,
  input  logic                     fetch_valid,
  input  logic [XLEN-1:0]          fetch_pc,
  input  logic                     data_load,
  input  logic                     data_store,
  input  logic [XLEN-1:0]          data_addr,
  input  logic [1:0]               data_lsize,
  output logic                     brk_req,
  output logic [IDX_W-1:0]         brk_idx
);

  logic [NUM_TRIG-1:0] exec_vec, data_vec;
  logic                exec_any, data_any;
  logic [IDX_W-1:0]    exec_idx, data_idx;
  logic                req_n;
  logic [IDX_W-1:0]    idx_n;

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_slot
    slot_hit_t h;
    trig_slot #(.XLEN(XLEN)) u_slot (
      .ctrl        (trig_ctrl[g*XLEN +: XLEN]),
      .taddr       (trig_addr[g*XLEN +: XLEN]),
      .priv        (priv_lvl),
      .fetch_valid (fetch_valid),
      .fetch_pc    (fetch_pc),
      .data_load   (data_load),
      .data_store  (data_store),
      .data_addr   (data_addr),
      .data_lsize  (data_lsize),
      .hit         (h)
    );
    assign exec_vec[g] = h.exec_hit;
    assign data_vec[g] = h.data_hit;

    // R4
    disarmed_silent_chk: assert property (@(posedge clk) disable iff (rst)
      (!(trig_ctrl[g*XLEN + CB_USER] | trig_ctrl[g*XLEN + CB_SUPER] |
         trig_ctrl[g*XLEN + CB_MACH]) ||
       !(|trig_ctrl[g*XLEN +: 3])) |-> !(h.exec_hit | h.data_hit));
  end

  first_hit_pick #(.N(NUM_TRIG), .IDX_W(IDX_W)) u_pick_exec (
    .hits (exec_vec),
    .any  (exec_any),
    .idx  (exec_idx)
  );

  first_hit_pick #(.N(NUM_TRIG), .IDX_W(IDX_W)) u_pick_data (
    .hits (data_vec),
    .any  (data_any),
    .idx  (data_idx)
  );

  // Instruction matches outrank data matches
  always_comb begin
    req_n = exec_any | data_any;
    if (exec_any)      idx_n = exec_idx;
    else if (data_any) idx_n = data_idx;
    else               idx_n = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      brk_req <= 1'b0;
      brk_idx <= '0;
    end else begin
      brk_req <= req_n;
      brk_idx <= idx_n;
    end
  end

  // R1
  exec_needs_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    exec_any |-> fetch_valid);

  // R2
  data_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    data_any |-> (data_load | data_store));

  // R8
  exec_wins_chk: assert property (@(posedge clk) disable iff (rst)
    exec_any |=> (brk_req && brk_idx == $past(exec_idx)));

  // R9
  no_spurious_req_chk: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> $past(fetch_valid | data_load | data_store));

  // R9
  idle_idx_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !brk_req |-> (brk_idx == '0));

endmodule

// File: tb/tb_dbg_match_unit.sv
module tb_dbg_match_unit;

  localparam int CLK_PERIOD = 10;
  localparam int XLEN       = 32;
  localparam int NT         = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       priv_lvl = 2'd3;
  logic [XLEN-1:0]  ctrl [NT];
  logic [XLEN-1:0]  tadr [NT];
  logic             fetch_valid = 1'b0;
  logic [XLEN-1:0]  fetch_pc = '0;
  logic             data_load = 1'b0;
  logic             data_store = 1'b0;
  logic [XLEN-1:0]  data_addr = '0;
  logic [1:0]       data_lsize = 2'd0;
  logic             brk_req;
  logic [0:0]       brk_idx;

  int    errors = 0;
  int    checks = 0;
  bit    done   = 0;
  string phase  = "R10";
  string exp_tag = "R10";
  bit    exp_req = 0;
  int    exp_idx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_match_unit #(.XLEN(XLEN), .NUM_TRIG(NT)) dut (
    .clk, .rst, .priv_lvl,
    .trig_ctrl ({ctrl[1], ctrl[0]}),
    .trig_addr ({tadr[1], tadr[0]}),
    .fetch_valid, .fetch_pc, .data_load, .data_store,
    .data_addr, .data_lsize, .brk_req, .brk_idx
  );

  // Control word builder: load b0, store b1, exec b2, U b3, S b4, M b6, size b17:16
  function automatic logic [XLEN-1:0] mk(bit ld, bit st, bit ex,
                                         bit u, bit s, bit m, int sz);
    logic [XLEN-1:0] c = '0;
    c[0] = ld; c[1] = st; c[2] = ex; c[3] = u; c[4] = s; c[6] = m;
    c[17:16] = sz[1:0];
    return c;
  endfunction

  // Behavioural reference: next-cycle request and index
  always @(posedge clk) begin
    int ex_i, dt_i;
    ex_i = -1; dt_i = -1;
    for (int i = NT - 1; i >= 0; i--) begin
      logic [XLEN-1:0] c;
      bit en, pv, hx, hd;
      longint wl, al, lo, wb;
      c  = ctrl[i];
      en = (c[3] || c[4] || c[6]) && (c[0] || c[1] || c[2]);
      pv = c[3 + priv_lvl];
      case (c[17:16])
        2'd0: wl = 8;
        2'd1: wl = 1;
        2'd2: wl = 2;
        default: wl = 4;
      endcase
      al = longint'(1) << data_lsize;
      lo = longint'(data_addr);
      wb = longint'(tadr[i]);
      hx = en && pv && c[2] && fetch_valid && (fetch_pc == tadr[i]);
      hd = en && pv && ((data_load && c[0]) || (data_store && c[1])) &&
           (lo < wb + wl) && (wb < lo + al);
      if (hx) ex_i = i;
      if (hd) dt_i = i;
    end
    exp_tag <= phase;
    if (rst) begin
      exp_req <= 0; exp_idx <= 0;
    end else if (ex_i >= 0) begin
      exp_req <= 1; exp_idx <= ex_i;
    end else if (dt_i >= 0) begin
      exp_req <= 1; exp_idx <= dt_i;
    end else begin
      exp_req <= 0; exp_idx <= 0;
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (brk_req !== exp_req || int'(brk_idx) !== exp_idx) begin
        errors++;
        $display("FAIL %s: req=%0b idx=%0d expected req=%0b idx=%0d",
                 exp_tag, brk_req, brk_idx, exp_req, exp_idx);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet();
    fetch_valid = 0; data_load = 0; data_store = 0;
  endtask

  task automatic fetch(logic [XLEN-1:0] pc);
    quiet(); fetch_valid = 1; fetch_pc = pc; tick(); quiet();
  endtask

  task automatic access(bit ld, bit st, logic [XLEN-1:0] a, int ls);
    quiet(); data_load = ld; data_store = st; data_addr = a;
    data_lsize = ls[1:0]; tick(); quiet();
  endtask

  task automatic finish_run();
    tick(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not end, expected finish");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    ctrl[0] = '0; ctrl[1] = '0; tadr[0] = '0; tadr[1] = '0;
    // R10: reset state, even with a matching fetch present
    phase = "R10";
    ctrl[0] = mk(0,0,1, 0,0,1, 0); tadr[0] = 32'h1000;
    fetch_valid = 1; fetch_pc = 32'h1000;
    tick(3);
    quiet();
    rst = 0;
    tick(2);

    // R1: exact instruction address match
    phase = "R1";
    priv_lvl = 2'd3;
    fetch(32'h1000); tick();
    fetch(32'h1001); fetch(32'h0FFF); tick();
    quiet(); fetch_pc = 32'h1000; tick(2);
    ctrl[0] = mk(1,1,0, 0,0,1, 0);
    fetch(32'h1000); tick();

    // R3: privilege filter
    phase = "R3";
    ctrl[0] = mk(0,0,1, 0,0,1, 0);
    for (int p = 0; p < 4; p++) begin priv_lvl = p[1:0]; fetch(32'h1000); end
    ctrl[0] = mk(0,0,1, 1,0,0, 0);
    for (int p = 0; p < 4; p++) begin priv_lvl = p[1:0]; fetch(32'h1000); end
    ctrl[0] = mk(0,0,1, 0,1,0, 0);
    for (int p = 0; p < 4; p++) begin priv_lvl = p[1:0]; fetch(32'h1000); end
    priv_lvl = 2'd3;

    // R4: disarmed triggers stay silent
    phase = "R4";
    ctrl[0] = mk(0,0,0, 1,1,1, 0);
    fetch(32'h1000); access(1,1,32'h1000,0);
    ctrl[0] = mk(1,1,1, 0,0,0, 0);
    for (int p = 0; p < 4; p++) begin
      priv_lvl = p[1:0]; fetch(32'h1000); access(1,1,32'h1000,2);
    end
    priv_lvl = 2'd3; ctrl[0] = '0; tick();

    // R5: window size per code, byte accesses walked across the edges
    phase = "R5";
    tadr[1] = 32'h2000;
    for (int sz = 0; sz < 4; sz++) begin
      ctrl[1] = mk(1,0,0, 0,0,1, sz);
      for (int k = -2; k < 10; k++) access(1,0, 32'h2000 + k, 0);
    end

    // R6: wider accesses overlapping a window partly
    phase = "R6";
    ctrl[1] = mk(1,0,0, 0,0,1, 2);
    access(1,0,32'h1FFE,1); access(1,0,32'h1FFF,1); access(1,0,32'h1FFC,2);
    access(1,0,32'h1FFD,2); access(1,0,32'h1FF8,3); access(1,0,32'h1FFA,3);
    access(1,0,32'h2001,3); access(1,0,32'h2002,0);
    tadr[1] = 32'hFFFF_FFFC; ctrl[1] = mk(1,0,0, 0,0,1, 0);
    access(1,0,32'hFFFF_FFFF,0); access(1,0,32'h0000_0000,3);
    access(1,0,32'hFFFF_FFF8,2);

    // R2: load and store kinds
    phase = "R2";
    tadr[1] = 32'h3000;
    ctrl[1] = mk(1,0,0, 0,0,1, 3);
    access(0,1,32'h3000,0); access(1,0,32'h3000,0);
    ctrl[1] = mk(0,1,0, 0,0,1, 3);
    access(1,0,32'h3000,0); access(0,1,32'h3002,0); access(1,1,32'h3003,0);
    ctrl[1] = mk(0,0,1, 0,0,1, 3);
    access(1,1,32'h3000,0);

    // R7: lowest index wins
    phase = "R7";
    tadr[0] = 32'h4000; tadr[1] = 32'h4000;
    ctrl[0] = mk(1,1,1, 0,0,1, 0); ctrl[1] = mk(1,1,1, 0,0,1, 0);
    fetch(32'h4000); access(1,0,32'h4004,0);
    ctrl[0] = mk(1,1,1, 1,0,0, 0);
    fetch(32'h4000); access(0,1,32'h4004,0);

    // R8: instruction match outranks a data match
    phase = "R8";
    priv_lvl = 2'd3;
    ctrl[0] = mk(1,0,0, 0,0,1, 0); tadr[0] = 32'h5000;
    ctrl[1] = mk(0,0,1, 0,0,1, 0); tadr[1] = 32'h6000;
    quiet(); fetch_valid = 1; fetch_pc = 32'h6000;
    data_load = 1; data_addr = 32'h5000; data_lsize = 0;
    tick(); quiet();
    fetch_valid = 1; fetch_pc = 32'h6001; data_load = 1;
    tick(); quiet(); tick();

    // R9: back-to-back matches and gaps
    phase = "R9";
    fetch_valid = 1; fetch_pc = 32'h6000; tick(3);
    quiet(); tick(2);
    fetch_valid = 1; tick(); quiet(); tick();
    fetch_valid = 1; tick(); quiet();

    // R10: reset in mid-run
    phase = "R10";
    fetch_valid = 1; tick();
    rst = 1; tick(2); rst = 0; quiet(); tick(2);

    // R2: mixed traffic near both triggers
    phase = "R2";
    tadr[0] = 32'h7000; tadr[1] = 32'h7004;
    for (int n = 0; n < 600; n++) begin
      if (n % 50 == 0) begin
        ctrl[0] = mk($urandom%2, $urandom%2, $urandom%2,
                     $urandom%2, $urandom%2, $urandom%2, $urandom%4);
        ctrl[1] = mk($urandom%2, $urandom%2, $urandom%2,
                     $urandom%2, $urandom%2, $urandom%2, $urandom%4);
      end
      priv_lvl    = 2'($urandom % 4);
      fetch_valid = 1'($urandom % 2);
      fetch_pc    = 32'h6FFC + ($urandom % 16);
      data_load   = 1'($urandom % 2);
      data_store  = 1'($urandom % 2);
      data_addr   = 32'h6FF8 + ($urandom % 24);
      data_lsize  = 2'($urandom % 4);
      tick();
    end
    quiet();
    finish_run();
  end

endmodule